// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block keeps one processor's small direct-mapped write-back data cache coherent with its peers on a shared, atomic snooping bus. Processor loads and stores are served from the local lines when the coherence state allows it. Otherwise the block becomes a bus master and issues a read, a read-for-ownership or a write-back. The bus is modelled as request, grant, then a single command/address cycle, followed by a whole-line data beat for fills.

At the same time the block watches the commands of other masters. It answers each one combinationally in the same cycle: it raises the wired-OR shared line when it holds a valid copy, supplies a dirty line by flushing it, and downgrades or invalidates its own copy. A fill samples the shared line. Unshared data is therefore installed exclusive-clean, and a later store to it needs no bus traffic.

Addresses are word addresses, split from the most significant end as tag, line index, then word offset. Bus addresses are line addresses, made of the tag followed by the index.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready_o` is 1, and `cpu_busy_o`, `cpu_resp_valid_o`, `bus_req_o`, `snoop_shared_o` and `snoop_flush_o` are 0. `bus_cmd_o` is 00. The first access to any address misses.
- R2: A read miss issues command 01 (read) carrying the line address. When the fill arrives, the line is installed Exclusive if `bus_shared_i` was 0 with the fill, and Shared if it was 1. `cpu_resp_valid_o` rises one cycle after the fill and returns the addressed word of the fill.
- R3: A store that hits an Exclusive line makes it Modified without any bus request.
- R4: A store to a Shared line, or a store that misses, issues command 10 (read for ownership). The filled line gets the stored word merged in and ends Modified.
- R5: A snooped read that hits a Modified line asserts `snoop_flush_o` with the current line on `snoop_data_o`, and leaves the line Shared.
- R6: A snooped read-for-ownership that hits a Modified line flushes the line and invalidates it.
- R7: A snooped read-for-ownership that hits a Shared or Exclusive line invalidates it without a flush and without asserting the shared line.
- R8: A snooped read asserts `snoop_shared_o` exactly when a valid copy with a matching tag is held, and moves an Exclusive line to Shared. A snooped address that misses changes nothing.
- R9: Loads and stores that hit Modified, and loads that hit Exclusive or Shared, make no bus request and respond one cycle after acceptance.
- R10: When a Modified line is displaced, command 11 (write-back) with the victim's line address and data is issued before the read of the new line. A clean victim is dropped with no write-back.
- R11: Command encoding is 00 idle, 01 read, 10 read for ownership, 11 write-back. A command other than 00 appears only in a cycle where `bus_gnt_i` is 1.
- R12: `cpu_ready_o` is 0 while a miss or upgrade is outstanding (`cpu_busy_o` 1) and in any cycle with a snooped command on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request valid |
| cpu_ready_o | output | 1 | Request accepted when high together with valid |
| cpu_we_i | input | 1 | 1 store, 0 load |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_resp_valid_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load data (store data echoed for stores) |
| cpu_busy_o | output | 1 | Miss or upgrade in progress |
| bus_req_o | output | 1 | Bus mastership request |
| bus_gnt_i | input | 1 | Grant; the cycle it is high is the command cycle |
| bus_cmd_o | output | 2 | Issued command |
| bus_addr_o | output | ADDR_W-OFF_W | Issued line address |
| bus_data_o | output | DATA_W*LINE_WORDS | Write-back line |
| bus_fill_valid_i | input | 1 | Fill data beat for own read |
| bus_fill_data_i | input | DATA_W*LINE_WORDS | Fill line |
| bus_shared_i | input | 1 | Wired-OR shared line, valid with the fill |
| snoop_cmd_i | input | 2 | Command of another master |
| snoop_addr_i | input | ADDR_W-OFF_W | Line address of that command |
| snoop_shared_o | output | 1 | Contribution to the wired-OR shared line |
| snoop_flush_o | output | 1 | This cache supplies the line |
| snoop_data_o | output | DATA_W*LINE_WORDS | Flushed line |

## Verification
Hits respond in the cycle after acceptance, misses in the cycle after the fill beat. Snoop replies are combinational and are checked in the same cycle that the command is on the bus. The bench drives inputs at the falling edge and samples just after it. It records the cycle of each acceptance, so it can demand a latency of exactly one for hits. The bus model compares every granted command, in order, against the queue of transactions the requirements predict. A transaction that is missing, extra or out of order is therefore caught, and that includes a write-back or a bus access that should never happen.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_WB   = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 3,
  parameter int LINE_W    = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [TAG_W-1:0]  a_tag_o,
  output mesi_e             a_st_o,
  output logic [LINE_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [TAG_W-1:0]  b_tag_o,
  output mesi_e             b_st_o,
  output logic [LINE_W-1:0] b_data_o,
  input  logic              w_en_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [TAG_W-1:0]  w_tag_i,
  input  mesi_e             w_st_i,
  input  logic [LINE_W-1:0] w_data_i,
  input  logic              s_en_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  mesi_e             s_st_i
);
  mesi_e             st_q   [NUM_LINES];
  logic [TAG_W-1:0]  tag_q  [NUM_LINES];
  logic [LINE_W-1:0] data_q [NUM_LINES];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[l]   <= ST_I;
        tag_q[l]  <= '0;
        data_q[l] <= '0;
      end else begin
        if (w_en_i && w_idx_i == IDX_W'(l)) begin
          st_q[l]   <= w_st_i;
          tag_q[l]  <= w_tag_i;
          data_q[l] <= w_data_i;
        end
        // snoop state update wins
        if (s_en_i && s_idx_i == IDX_W'(l)) st_q[l] <= s_st_i;
      end
    end
  end

  assign a_tag_o  = tag_q[a_idx_i];
  assign a_st_o   = st_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];

  AST_NO_PORT_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_en_i && s_en_i)) else $error("local and snoop update in same cycle"); // R12
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_cmd_e          cmd_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  mesi_e             line_st_i,
  input  logic [LINE_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              flush_o,
  output logic [LINE_W-1:0] flush_data_o,
  output logic              upd_en_o,
  output mesi_e             upd_st_o
);
  logic hit;
  assign hit = (line_st_i != ST_I) && (line_tag_i == tag_i);

  always_comb begin
    shared_o = 1'b0;
    flush_o  = 1'b0;
    upd_en_o = 1'b0;
    upd_st_o = line_st_i;
    if (hit) begin
      unique case (cmd_i)
        CMD_RD: begin
          shared_o = 1'b1;
          flush_o  = (line_st_i == ST_M);
          upd_en_o = (line_st_i != ST_S);
          upd_st_o = ST_S;
        end
        CMD_RDX: begin
          flush_o  = (line_st_i == ST_M);
          upd_en_o = 1'b1;
          upd_st_o = ST_I;
        end
        default: ;
      endcase
    end
  end

  assign flush_data_o = flush_o ? line_data_i : '0;

  AST_RDX_NOT_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RDX) |-> !shared_o) else $error("shared on ownership read"); // R7
  AST_FLUSH_ONLY_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (upd_en_o && line_st_i == ST_M)) else $error("flush of clean line"); // R5
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int OFF_W      = 2,
  parameter int IDX_W      = 3,
  parameter int TAG_W      = 3,
  parameter int LINE_W     = 128,
  parameter int LADDR_W    = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_valid_i,
  output logic               cpu_ready_o,
  input  logic               cpu_we_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic               cpu_resp_valid_o,
  output logic [DATA_W-1:0]  cpu_rdata_o,
  output logic               cpu_busy_o,
  input  logic               snoop_active_i,
  output logic               bus_req_o,
  input  logic               bus_gnt_i,
  output bus_cmd_e           bus_cmd_o,
  output logic [LADDR_W-1:0] bus_addr_o,
  output logic [LINE_W-1:0]  bus_data_o,
  input  logic               bus_fill_valid_i,
  input  logic [LINE_W-1:0]  bus_fill_data_i,
  input  logic               bus_shared_i,
  output logic [IDX_W-1:0]   a_idx_o,
  input  logic [TAG_W-1:0]   a_tag_i,
  input  mesi_e              a_st_i,
  input  logic [LINE_W-1:0]  a_data_i,
  output logic               w_en_o,
  output logic [IDX_W-1:0]   w_idx_o,
  output logic [TAG_W-1:0]   w_tag_o,
  output mesi_e              w_st_o,
  output logic [LINE_W-1:0]  w_data_o
);
  typedef enum logic [1:0] {F_IDLE, F_WB, F_REQ, F_FILL} fsm_e;

  fsm_e              fsm_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  off;
  logic tag_hit, hit_ok, victim_dirty, accept;

  function automatic logic [DATA_W-1:0] pick(input logic [LINE_W-1:0] line,
                                             input logic [OFF_W-1:0] o);
    pick = '0;
    for (int w = 0; w < LINE_WORDS; w++)
      if (OFF_W'(w) == o) pick = line[w*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] line,
                                              input logic [OFF_W-1:0] o,
                                              input logic [DATA_W-1:0] wd);
    merge = line;
    for (int w = 0; w < LINE_WORDS; w++)
      if (OFF_W'(w) == o) merge[w*DATA_W +: DATA_W] = wd;
  endfunction

  assign cur_addr     = (fsm_q == F_IDLE) ? cpu_addr_i : req_addr_q;
  assign off          = cur_addr[OFF_W-1:0];
  assign idx          = cur_addr[OFF_W +: IDX_W];
  assign tag          = cur_addr[ADDR_W-1 -: TAG_W];
  assign a_idx_o      = idx;
  assign tag_hit      = (a_st_i != ST_I) && (a_tag_i == tag);
  assign hit_ok       = tag_hit && (!cpu_we_i || a_st_i == ST_M || a_st_i == ST_E);
  assign victim_dirty = (a_st_i == ST_M) && (a_tag_i != tag);

  assign cpu_ready_o = (fsm_q == F_IDLE) && !snoop_active_i;
  assign cpu_busy_o  = (fsm_q != F_IDLE);
  assign accept      = cpu_valid_i && cpu_ready_o;

  assign bus_req_o = (fsm_q == F_WB && victim_dirty) || (fsm_q == F_REQ);

  always_comb begin
    bus_cmd_o  = CMD_IDLE;
    bus_addr_o = '0;
    bus_data_o = '0;
    if (bus_gnt_i && fsm_q == F_WB && victim_dirty) begin
      bus_cmd_o  = CMD_WB;
      bus_addr_o = {a_tag_i, idx};
      bus_data_o = a_data_i;
    end else if (bus_gnt_i && fsm_q == F_REQ) begin
      bus_cmd_o  = req_we_q ? CMD_RDX : CMD_RD;
      bus_addr_o = {tag, idx};
    end
  end

  always_comb begin
    w_en_o   = 1'b0;
    w_idx_o  = idx;
    w_tag_o  = tag;
    w_st_o   = a_st_i;
    w_data_o = a_data_i;
    unique case (fsm_q)
      F_IDLE: if (accept && hit_ok && cpu_we_i) begin
        w_en_o   = 1'b1;
        w_st_o   = ST_M;
        w_data_o = merge(a_data_i, off, cpu_wdata_i);
      end
      F_WB: if (bus_cmd_o == CMD_WB) begin
        w_en_o  = 1'b1;
        w_tag_o = a_tag_i;
        w_st_o  = ST_I;
      end
      F_FILL: if (bus_fill_valid_i) begin
        w_en_o   = 1'b1;
        w_st_o   = req_we_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
        w_data_o = req_we_q ? merge(bus_fill_data_i, off, req_wdata_q) : bus_fill_data_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q            <= F_IDLE;
      req_we_q         <= 1'b0;
      req_addr_q       <= '0;
      req_wdata_q      <= '0;
      cpu_resp_valid_o <= 1'b0;
      cpu_rdata_o      <= '0;
    end else begin
      cpu_resp_valid_o <= 1'b0;
      unique case (fsm_q)
        F_IDLE: if (accept) begin
          if (hit_ok) begin
            cpu_resp_valid_o <= 1'b1;
            cpu_rdata_o      <= cpu_we_i ? cpu_wdata_i : pick(a_data_i, off);
          end else begin
            req_we_q    <= cpu_we_i;
            req_addr_q  <= cpu_addr_i;
            req_wdata_q <= cpu_wdata_i;
            fsm_q       <= victim_dirty ? F_WB : F_REQ;
          end
        end
        // victim may have been cleaned by a snoop while waiting
        F_WB:   if (!victim_dirty || bus_gnt_i) fsm_q <= F_REQ;
        F_REQ:  if (bus_gnt_i) fsm_q <= F_FILL;
        F_FILL: if (bus_fill_valid_i) begin
          cpu_resp_valid_o <= 1'b1;
          cpu_rdata_o      <= req_we_q ? req_wdata_q : pick(bus_fill_data_i, off);
          fsm_q            <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  AST_E_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cpu_we_i && tag_hit && a_st_i == ST_E) |=> (!bus_req_o && cpu_resp_valid_o))
    else $error("exclusive store went to bus"); // R3
  AST_HIT_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit_ok) |=> (!bus_req_o && !cpu_busy_o && cpu_resp_valid_o))
    else $error("hit caused bus request"); // R9
  AST_WB_BEFORE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == CMD_RD || bus_cmd_o == CMD_RDX) |-> !victim_dirty)
    else $error("fetch issued over dirty victim"); // R10
  AST_CMD_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != CMD_IDLE) |-> (bus_gnt_i && bus_req_o))
    else $error("command without grant"); // R11
  AST_FILL_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_FILL && bus_fill_valid_i) |=> (cpu_resp_valid_o && !cpu_busy_o))
    else $error("fill without response"); // R2
  AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_busy_o |-> !cpu_ready_o) else $error("ready while busy"); // R12
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = DATA_W * LINE_WORDS,
  localparam int LADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_valid_i,
  output logic               cpu_ready_o,
  input  logic               cpu_we_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic               cpu_resp_valid_o,
  output logic [DATA_W-1:0]  cpu_rdata_o,
  output logic               cpu_busy_o,
  output logic               bus_req_o,
  input  logic               bus_gnt_i,
  output logic [1:0]         bus_cmd_o,
  output logic [LADDR_W-1:0] bus_addr_o,
  output logic [LINE_W-1:0]  bus_data_o,
  input  logic               bus_fill_valid_i,
  input  logic [LINE_W-1:0]  bus_fill_data_i,
  input  logic               bus_shared_i,
  input  logic [1:0]         snoop_cmd_i,
  input  logic [LADDR_W-1:0] snoop_addr_i,
  output logic               snoop_shared_o,
  output logic               snoop_flush_o,
  output logic [LINE_W-1:0]  snoop_data_o
);
  logic [IDX_W-1:0]  a_idx, w_idx;
  logic [TAG_W-1:0]  a_tag, b_tag, w_tag;
  mesi_e             a_st, b_st, w_st, s_st;
  logic [LINE_W-1:0] a_data, b_data, w_data;
  logic              w_en, s_en;
  bus_cmd_e          fsm_cmd, snp_cmd;

  assign snp_cmd   = bus_cmd_e'(snoop_cmd_i);
  assign bus_cmd_o = fsm_cmd;

  mesi_line_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_idx_i(a_idx), .a_tag_o(a_tag), .a_st_o(a_st), .a_data_o(a_data),
    .b_idx_i(snoop_addr_i[IDX_W-1:0]), .b_tag_o(b_tag), .b_st_o(b_st), .b_data_o(b_data),
    .w_en_i(w_en), .w_idx_i(w_idx), .w_tag_i(w_tag), .w_st_i(w_st), .w_data_i(w_data),
    .s_en_i(s_en), .s_idx_i(snoop_addr_i[IDX_W-1:0]), .s_st_i(s_st)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_snoop (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_i(snp_cmd), .tag_i(snoop_addr_i[LADDR_W-1 -: TAG_W]),
    .line_tag_i(b_tag), .line_st_i(b_st), .line_data_i(b_data),
    .shared_o(snoop_shared_o), .flush_o(snoop_flush_o), .flush_data_o(snoop_data_o),
    .upd_en_o(s_en), .upd_st_o(s_st)
  );

  mesi_cpu_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W), .LADDR_W(LADDR_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_valid_i(cpu_valid_i), .cpu_ready_o(cpu_ready_o), .cpu_we_i(cpu_we_i),
    .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_resp_valid_o(cpu_resp_valid_o), .cpu_rdata_o(cpu_rdata_o), .cpu_busy_o(cpu_busy_o),
    .snoop_active_i(snp_cmd != CMD_IDLE),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_cmd_o(fsm_cmd),
    .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .bus_fill_valid_i(bus_fill_valid_i), .bus_fill_data_i(bus_fill_data_i),
    .bus_shared_i(bus_shared_i),
    .a_idx_o(a_idx), .a_tag_i(a_tag), .a_st_i(a_st), .a_data_i(a_data),
    .w_en_o(w_en), .w_idx_o(w_idx), .w_tag_o(w_tag), .w_st_o(w_st), .w_data_o(w_data)
  );

  AST_SNOOP_RDX_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_cmd == CMD_RDX && b_st != ST_I && b_tag == snoop_addr_i[LADDR_W-1 -: TAG_W])
    |=> (b_st == ST_I || $past(snoop_addr_i) != snoop_addr_i))
    else $error("copy survived ownership read"); // R6
  AST_SNOOP_NO_STALL_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_cmd != CMD_IDLE) |-> !cpu_ready_o) else $error("ready during snoop"); // R12
endmodule

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;
  localparam int AW = 8, DW = 32, LA = 6, LW = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_valid = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_resp_valid, cpu_busy;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, gnt = 0, fill_valid = 0, shared_in = 0;
  logic [1:0]    bus_cmd;
  logic [LA-1:0] bus_addr;
  logic [LW-1:0] bus_data, fill_data = '0;
  logic [1:0]    snoop_cmd = 2'b00;
  logic [LA-1:0] snoop_addr = '0;
  logic          snoop_shared, snoop_flush;
  logic [LW-1:0] snoop_data;

  mesi_snoop_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_ready_o(cpu_ready), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_resp_valid_o(cpu_resp_valid), .cpu_rdata_o(cpu_rdata), .cpu_busy_o(cpu_busy),
    .bus_req_o(bus_req), .bus_gnt_i(gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_data_o(bus_data), .bus_fill_valid_i(fill_valid), .bus_fill_data_i(fill_data),
    .bus_shared_i(shared_in), .snoop_cmd_i(snoop_cmd), .snoop_addr_i(snoop_addr),
    .snoop_shared_o(snoop_shared), .snoop_flush_o(snoop_flush), .snoop_data_o(snoop_data)
  );

  int checks = 0, errors = 0, cyc = 0, pending = 0;
  bit ext_shared = 0;
  logic [LW-1:0] mem [64];
  logic [LW-1:0] truth [64];

  typedef struct { bit rd; logic [DW-1:0] data; bit hit; int acc; } resp_t;
  typedef struct { logic [1:0] cmd; logic [LA-1:0] addr; bit chk; logic [LW-1:0] data; } bus_t;
  resp_t resp_q[$];
  string msg_q[$];
  bus_t  bus_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wa(input int t, input int i, input int o);
    return {t[2:0], i[2:0], o[1:0]};
  endfunction
  function automatic logic [LA-1:0] la(input int t, input int i);
    return {t[2:0], i[2:0]};
  endfunction

  task automatic expect_bus(input logic [1:0] c, input logic [LA-1:0] a, input bit d);
    bus_t e;
    e.cmd = c; e.addr = a; e.chk = d; e.data = truth[a];
    bus_q.push_back(e);
  endtask

  // bus arbiter and memory
  initial begin
    logic [1:0] c; logic [LA-1:0] a; logic [LW-1:0] d; bus_t e;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        gnt = 1'b1; #1;
        c = bus_cmd; a = bus_addr; d = bus_data;
        if (bus_q.size() == 0) chk(0, "R9 unexpected bus transaction", LW'(c), 0);
        else begin
          e = bus_q.pop_front();
          chk(c == e.cmd, "R11 bus command code", LW'(c), LW'(e.cmd));
          chk(a == e.addr, "R2 bus line address", LW'(a), LW'(e.addr));
          if (e.chk) chk(d == e.data, "R10 write-back data", d, e.data);
        end
        @(negedge clk);
        gnt = 1'b0; #1;
        chk(bus_cmd == 2'b00, "R11 command after grant", LW'(bus_cmd), 0);
        if (c == 2'b11) mem[a] = d;
        else if (c != 2'b00) begin
          fill_valid = 1'b1; fill_data = mem[a]; shared_in = ext_shared;
          @(negedge clk);
          fill_valid = 1'b0; shared_in = 1'b0;
        end
      end
    end
  end

  // response monitor
  initial begin
    resp_t r; string m;
    forever begin
      @(negedge clk);
      if (cpu_resp_valid) begin
        if (resp_q.size() == 0) chk(0, "R9 unexpected response", 0, 0);
        else begin
          r = resp_q.pop_front(); m = msg_q.pop_front();
          if (r.rd) chk(cpu_rdata == r.data, {m, " read data"}, LW'(cpu_rdata), LW'(r.data));
          if (r.hit) chk(cyc == r.acc + 1, "R9 hit latency", LW'(cyc), LW'(r.acc + 1));
          pending--;
        end
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input bit hit, input string m);
    resp_t r; int l, o;
    l = int'(addr[7:2]); o = int'(addr[1:0]);
    if (we) truth[l][o*DW +: DW] = wd;
    r.rd = !we; r.hit = hit; r.data = truth[l][o*DW +: DW];
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    r.acc = cyc;
    resp_q.push_back(r); msg_q.push_back(m); pending++;
    @(negedge clk);
    cpu_valid = 1'b0; #1;
    if (!hit) chk(cpu_busy && !cpu_ready, "R12 stall during miss", LW'({cpu_busy, cpu_ready}), LW'(2'b10));
    while (pending != 0 || cpu_busy) @(negedge clk);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [LA-1:0] a, input bit sh, input bit fl,
                       input string m);
    @(negedge clk);
    snoop_cmd = c; snoop_addr = a; #1;
    chk(snoop_shared == sh, {m, " shared line"}, LW'(snoop_shared), LW'(sh));
    chk(snoop_flush == fl, {m, " flush"}, LW'(snoop_flush), LW'(fl));
    if (fl) begin
      chk(snoop_data == truth[a], {m, " flush data"}, snoop_data, truth[a]);
      mem[a] = snoop_data;
    end
    chk(!cpu_ready, "R12 ready during snoop", LW'(cpu_ready), 0);
    @(negedge clk);
    snoop_cmd = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 64; l++) begin
      for (int w = 0; w < 4; w++) mem[l][w*DW +: DW] = 32'hA500_0000 + l * 16 + w;
      truth[l] = mem[l];
    end
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_ready && !cpu_busy && !cpu_resp_valid && !bus_req && bus_cmd == 2'b00 &&
        !snoop_shared && !snoop_flush, "R1 reset outputs",
        LW'({cpu_ready, cpu_busy, cpu_resp_valid, bus_req, bus_cmd, snoop_shared, snoop_flush}),
        LW'(8'b1000_0000));
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R2: cold read miss, no sharer -> Exclusive
    ext_shared = 0;
    expect_bus(2'b01, la(1, 0), 0);
    cpu_op(0, wa(1, 0, 2), 0, 0, "R1 R2 cold read miss");
    // R3: store to Exclusive is silent
    cpu_op(1, wa(1, 0, 2), 32'hDEAD_0001, 1, "R3 exclusive store");
    // R9: read hit in Modified
    cpu_op(0, wa(1, 0, 2), 0, 1, "R9 modified read hit");
    // R5/R8: snooped read on Modified flushes and drops to Shared
    snoop(2'b01, la(1, 0), 1, 1, "R5 snoop read on modified");
    // R4: store to Shared needs ownership read
    expect_bus(2'b10, la(1, 0), 0);
    cpu_op(1, wa(1, 0, 1), 32'hBEEF_0002, 0, "R4 shared store upgrade");
    // R6: snooped ownership read on Modified flushes and invalidates
    snoop(2'b10, la(1, 0), 0, 1, "R6 snoop ownership on modified");
    truth[la(1, 0)][0 +: DW] = 32'h0BAD_F00D;
    mem[la(1, 0)] = truth[la(1, 0)];
    ext_shared = 1;
    expect_bus(2'b01, la(1, 0), 0);
    cpu_op(0, wa(1, 0, 0), 0, 0, "R6 R2 reread after invalidate, sharer present");
    // R8: snooped read on Shared: shared asserted, no flush
    snoop(2'b01, la(1, 0), 1, 0, "R8 snoop read on shared");
    cpu_op(0, wa(1, 0, 0), 0, 1, "R9 shared read hit");
    // R7: ownership read on Shared invalidates silently
    snoop(2'b10, la(1, 0), 0, 0, "R7 snoop ownership on shared");
    ext_shared = 0;
    expect_bus(2'b01, la(1, 0), 0);
    cpu_op(0, wa(1, 0, 3), 0, 0, "R7 miss after silent invalidate");
    // R8: snooped read on Exclusive moves to Shared, so next store upgrades
    snoop(2'b01, la(1, 0), 1, 0, "R8 snoop read on exclusive");
    expect_bus(2'b10, la(1, 0), 0);
    cpu_op(1, wa(1, 0, 3), 32'hCAFE_0003, 0, "R8 store after exclusive downgrade");
    // R8: snoops that miss change nothing
    snoop(2'b01, la(2, 0), 0, 0, "R8 snoop tag miss");
    snoop(2'b10, la(1, 5), 0, 0, "R8 snoop invalid index");
    // R10: dirty victim written back before fetch
    expect_bus(2'b11, la(1, 0), 1);
    expect_bus(2'b01, la(2, 0), 0);
    cpu_op(0, wa(2, 0, 1), 0, 0, "R10 dirty victim replacement");
    // R10: clean victim dropped, earlier write-back visible in memory
    expect_bus(2'b01, la(1, 0), 0);
    cpu_op(0, wa(1, 0, 3), 0, 0, "R10 clean victim replacement");
    // R4: store miss, then Modified hits
    expect_bus(2'b10, la(3, 4), 0);
    cpu_op(1, wa(3, 4, 0), 32'h1234_5678, 0, "R4 store miss");
    cpu_op(0, wa(3, 4, 0), 0, 1, "R9 read of merged word");
    cpu_op(0, wa(3, 4, 2), 0, 1, "R4 fill word kept");
    cpu_op(1, wa(3, 4, 1), 32'h8765_4321, 1, "R9 modified store hit");
    repeat (4) @(negedge clk);
    chk(bus_q.size() == 0, "R10 expected bus transactions left", LW'(bus_q.size()), 0);
    chk(resp_q.size() == 0, "R2 responses left", LW'(resp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule